// File: doc/BRIEF.md
# Floating-Point Error Response Controller

This block settles what happens to an error-sensitive floating-point or wait instruction when it reaches execution while an unmasked floating-point exception may be outstanding. A numeric-error mode bit chooses between two policies. In internal-trap mode the block raises the floating-point error exception (vector 0x10). In external mode it consults an ignore-error pin from system logic. A sampled ignore lets the instruction continue with the exception discarded. A negated ignore stalls the instruction until either the ignore pin or one of the interrupt-class inputs releases it.

The instruction is offered over a valid/ready handshake. The execution stage raises `tgt_valid` and must hold it, together with `exc_pending`, `err_sens` and `ne_mode`, stable until it sees `tgt_ready`. `tgt_ready` rises for exactly one cycle, in the same cycle as the single outcome pulse. No new instruction is taken while a decision is open, so the handshake has no skid storage.

The ignore pin and the four interrupt-class inputs may change at any time with respect to the clock. Each passes through a two-flop synchronizer. The power-state indications and the probe-ready input come from on-chip logic and are used directly. They only gate when the ignore pin counts as sampled.

Top module: `fperr_resp_top`

## Requirements
- R1: When `tgt_valid` is sampled high in idle and `exc_pending` or `err_sens` is low, `go_o` and `tgt_ready` pulse in the next cycle, whatever the other inputs are.
- R2: With `exc_pending` and `err_sens` high and `ne_mode` = 1, `trap_o` pulses in the next cycle and `trap_vec` reads 0x10. The ignore pin has no effect on this outcome.
- R3: With `ne_mode` = 0 and the synchronized ignore pin sampled asserted, `go_o` pulses in the next cycle.
- R4: With `ne_mode` = 0 and the ignore pin sampled negated, the block enters the wait state. `stall_o` is high there, and no outcome pulse or `tgt_ready` occurs until a release.
- R5: In the wait state, the ignore pin sampled asserted ends the wait with a `go_o` pulse.
- R6: In the wait state, any of `intr_i`, `smi_i`, `nmi_i` or `init_i` sampled asserted ends the wait with an `irq_exit_o` pulse.
- R7: When the ignore pin and an interrupt-class input are both sampled asserted in the same wait cycle, the outcome is `irq_exit_o`.
- R8: The ignore pin counts as negated while any of `pwr_shutdown`, `pwr_halt`, `pwr_stopgnt`, `pwr_stopclk`, `probe_rdy` or the synchronized `init_i` is high.
- R9: An asynchronous input is seen only after two synchronizer flops. An ignore pin raised during the wait gives `go_o` three rising edges later, and not before.
- R10: Reset (`rst_n` low) returns the block to idle and clears a wait in progress. At most one outcome output is high at a time, and each outcome lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ne_mode | input | 1 | 1: trap internally; 0: use the ignore pin |
| exc_pending | input | 1 | Unmasked floating-point exception outstanding |
| err_sens | input | 1 | Target instruction is error-sensitive |
| tgt_valid | input | 1 | Target instruction offered |
| tgt_ready | output | 1 | Decision made; instruction consumed |
| ign_pin | input | 1 | Ignore-error pin, asynchronous |
| intr_i | input | 1 | Maskable interrupt, asynchronous |
| smi_i | input | 1 | System-management interrupt, asynchronous |
| nmi_i | input | 1 | Non-maskable interrupt, asynchronous |
| init_i | input | 1 | Init request, asynchronous |
| probe_rdy | input | 1 | Debug probe ready; blocks sampling |
| pwr_shutdown | input | 1 | Shutdown state |
| pwr_halt | input | 1 | Halt state |
| pwr_stopgnt | input | 1 | Stop-grant state |
| pwr_stopclk | input | 1 | Stop-clock state |
| go_o | output | 1 | Pulse: instruction proceeds |
| trap_o | output | 1 | Pulse: raise floating-point error exception |
| trap_vec | output | 8 | Vector number of the raised exception |
| irq_exit_o | output | 1 | Pulse: leave wait for interrupt service |
| stall_o | output | 1 | Instruction held in the wait state |

## Verification
The bench puts the ignore pin high in trap mode. A design that let the pin win there would proceed instead of trapping. It raises the ignore pin and a non-maskable interrupt in the same wait cycle, which a design with the wrong priority resolves as a proceed. It holds the ignore pin high during halt and during probe-ready, where a design without the sampling gate would never wait. It also times the release from an ignore edge, resets in the middle of a wait, and confirms that every outcome and its ready are single-cycle and come from the scoreboard's expected sequence.

// File: rtl/fperr_pkg.sv
package fperr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } fe_state_e;

  typedef enum logic [1:0] {
    OC_NONE = 2'd0,
    OC_GO   = 2'd1,
    OC_TRAP = 2'd2,
    OC_IRQ  = 2'd3
  } fe_outcome_e;

  // interrupt-class inputs: maskable, system-management, non-maskable, init
  localparam int NUM_IRQ   = 4;
  localparam int IRQ_INIT  = 3;
  localparam int NUM_PWR   = 4;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/fperr_sync.sv
module fperr_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fperr_sample_gate.sv
module fperr_sample_gate #(
  parameter int NPWR = 4
) (
  input  logic            ign_s,
  input  logic            init_s,
  input  logic            probe_rdy,
  input  logic [NPWR-1:0] pwr_state,
  output logic            ign_ok
);
  logic blocked;

  always_comb begin
    blocked = (|pwr_state) | init_s | probe_rdy;
    ign_ok  = ign_s & ~blocked;
  end
endmodule

// File: rtl/fperr_ctrl.sv
module fperr_ctrl
  import fperr_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ne_mode_i,
  input  logic            exc_pending_i,
  input  logic            err_sens_i,
  input  logic            tgt_valid_i,
  input  logic            ign_ok_i,
  input  logic [NIRQ-1:0] irq_s_i,
  output logic            go_o,
  output logic            trap_o,
  output logic            irq_o,
  output logic            stall_o,
  output logic            ready_o
);
  fe_state_e   st_q, st_d;
  fe_outcome_e oc_q, oc_d;
  logic        armed;
  logic        irq_any;

  always_comb begin
    armed   = exc_pending_i & err_sens_i;
    irq_any = |irq_s_i;
    st_d    = st_q;
    oc_d    = oc_q;
    unique case (st_q)
      ST_IDLE: begin
        oc_d = OC_NONE;
        if (tgt_valid_i) begin
          if (!armed) begin
            st_d = ST_RESP; oc_d = OC_GO;
          end else if (ne_mode_i) begin
            st_d = ST_RESP; oc_d = OC_TRAP;
          end else if (ign_ok_i) begin
            st_d = ST_RESP; oc_d = OC_GO;
          end else begin
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (irq_any) begin
          st_d = ST_RESP; oc_d = OC_IRQ;
        end else if (ign_ok_i) begin
          st_d = ST_RESP; oc_d = OC_GO;
        end
      end
      ST_RESP: begin
        st_d = ST_IDLE; oc_d = OC_NONE;
      end
      default: begin
        st_d = ST_IDLE; oc_d = OC_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      oc_q <= OC_NONE;
    end else begin
      st_q <= st_d;
      oc_q <= oc_d;
    end
  end

  always_comb begin
    go_o    = (st_q == ST_RESP) && (oc_q == OC_GO);
    trap_o  = (st_q == ST_RESP) && (oc_q == OC_TRAP);
    irq_o   = (st_q == ST_RESP) && (oc_q == OC_IRQ);
    ready_o = (st_q == ST_RESP);
    stall_o = (st_q == ST_WAIT);
  end

  // R10: outcomes mutually exclusive
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_o, trap_o, irq_o}));

  // R10: each outcome lasts exactly one cycle
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o | trap_o | irq_o) |=> !(go_o | trap_o | irq_o));

  // R2: a trap only follows trap mode
  a_r2_trap_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(ne_mode_i));

  // R6: interrupt exit only leaves the wait state
  a_r6_irq_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(st_q == ST_WAIT));

  // R7: an interrupt seen while waiting always wins
  a_r7_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && irq_any) |=> irq_o);

  // R4: stall and ready never coincide
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !ready_o);
endmodule

// File: rtl/fperr_resp_top.sv
module fperr_resp_top
  import fperr_pkg::*;
#(
  parameter int              VEC_W       = 8,
  parameter logic [VEC_W-1:0] TRAP_VECTOR = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ne_mode,
  input  logic             exc_pending,
  input  logic             err_sens,
  input  logic             tgt_valid,
  output logic             tgt_ready,
  input  logic             ign_pin,
  input  logic             intr_i,
  input  logic             smi_i,
  input  logic             nmi_i,
  input  logic             init_i,
  input  logic             probe_rdy,
  input  logic             pwr_shutdown,
  input  logic             pwr_halt,
  input  logic             pwr_stopgnt,
  input  logic             pwr_stopclk,
  output logic             go_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec,
  output logic             irq_exit_o,
  output logic             stall_o
);
  localparam int SYNC_W = NUM_IRQ + 1;

  logic [SYNC_W-1:0]  raw_in, sync_out;
  logic [NUM_IRQ-1:0] irq_s;
  logic               ign_s, ign_ok;

  assign raw_in = {init_i, nmi_i, smi_i, intr_i, ign_pin};

  fperr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (sync_out)
  );

  assign ign_s = sync_out[0];
  assign irq_s = sync_out[SYNC_W-1:1];

  fperr_sample_gate #(.NPWR(NUM_PWR)) u_gate (
    .ign_s     (ign_s),
    .init_s    (irq_s[IRQ_INIT]),
    .probe_rdy (probe_rdy),
    .pwr_state ({pwr_stopclk, pwr_stopgnt, pwr_halt, pwr_shutdown}),
    .ign_ok    (ign_ok)
  );

  fperr_ctrl #(.NIRQ(NUM_IRQ)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ne_mode_i     (ne_mode),
    .exc_pending_i (exc_pending),
    .err_sens_i    (err_sens),
    .tgt_valid_i   (tgt_valid),
    .ign_ok_i      (ign_ok),
    .irq_s_i       (irq_s),
    .go_o          (go_o),
    .trap_o        (trap_o),
    .irq_o         (irq_exit_o),
    .stall_o       (stall_o),
    .ready_o       (tgt_ready)
  );

  assign trap_vec = TRAP_VECTOR;
endmodule

// File: tb/sim_fperr_resp_top.sv
module sim_fperr_resp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ne_mode = 0, exc_pending = 0, err_sens = 0, tgt_valid = 0;
  logic ign_pin = 0, intr_i = 0, smi_i = 0, nmi_i = 0, init_i = 0;
  logic probe_rdy = 0, pwr_shutdown = 0, pwr_halt = 0, pwr_stopgnt = 0, pwr_stopclk = 0;
  logic tgt_ready, go_o, trap_o, irq_exit_o, stall_o;
  logic [7:0] trap_vec;

  int checks = 0;
  int errors = 0;
  int exp_q[$];   // 1 = go, 2 = trap, 3 = irq exit
  bit finished = 0;

  always #5 clk = ~clk;

  fperr_resp_top u0 (
    .clk(clk), .rst_n(rst_n), .ne_mode(ne_mode), .exc_pending(exc_pending),
    .err_sens(err_sens), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
    .ign_pin(ign_pin), .intr_i(intr_i), .smi_i(smi_i), .nmi_i(nmi_i),
    .init_i(init_i), .probe_rdy(probe_rdy), .pwr_shutdown(pwr_shutdown),
    .pwr_halt(pwr_halt), .pwr_stopgnt(pwr_stopgnt), .pwr_stopclk(pwr_stopclk),
    .go_o(go_o), .trap_o(trap_o), .trap_vec(trap_vec),
    .irq_exit_o(irq_exit_o), .stall_o(stall_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every outcome
  always @(negedge clk) begin
    if (rst_n && (go_o || trap_o || irq_exit_o)) begin
      int got;
      got = go_o ? 1 : (trap_o ? 2 : 3);
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected outcome", got, 0);
      end else begin
        int want;
        want = exp_q.pop_front();
        check(got == want, "R1-7 outcome code", got, want);
      end
      check(tgt_ready == 1'b1, "R10 ready with outcome", tgt_ready, 1);
      check(int'(go_o) + int'(trap_o) + int'(irq_exit_o) == 1, "R10 one outcome",
            int'(go_o) + int'(trap_o) + int'(irq_exit_o), 1);
      if (trap_o) check(trap_vec == 8'h10, "R2 vector", trap_vec, 16);
    end
  end

  task automatic setup(input bit ne, input bit pend, input bit sens, input bit ign,
                       input bit [3:0] irq, input bit halt, input bit probe);
    @(negedge clk);
    ne_mode = ne; exc_pending = pend; err_sens = sens; ign_pin = ign;
    {init_i, nmi_i, smi_i, intr_i} = irq;
    pwr_halt = halt; probe_rdy = probe;
    repeat (4) @(negedge clk);
  endtask

  task automatic offer_expect(input int code);
    exp_q.push_back(code);
    tgt_valid = 1;
    @(negedge clk);
    while (!tgt_ready) @(negedge clk);
    tgt_valid = 0;
    @(negedge clk);
    check(!go_o && !trap_o && !irq_exit_o, "R10 pulse width", go_o, 0);
  endtask

  task automatic enter_wait(input string req);
    tgt_valid = 1;
    repeat (4) @(negedge clk);
    check(stall_o == 1'b1, req, stall_o, 1);
    check(tgt_ready == 1'b0, req, tgt_ready, 0);
  endtask

  task automatic finish_wait(input int code);
    @(negedge clk);
    while (!tgt_ready) @(negedge clk);
    tgt_valid = 0;
    @(negedge clk);
    check(exp_q.size() == 0, "R5/R6 scoreboard drained", exp_q.size(), 0);
    check(stall_o == 1'b0, "R4 stall cleared", stall_o, 0);
    if (code == 0) ;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(stall_o == 0 && tgt_ready == 0, "R10 reset idle", stall_o, 0);
    check(!go_o && !trap_o && !irq_exit_o, "R10 reset no outcome", go_o, 0);
    rst_n = 1;

    // R1: nothing pending, even in trap mode
    setup(1, 0, 1, 0, 4'b0000, 0, 0); offer_expect(1);
    // R1: not error-sensitive
    setup(1, 1, 0, 0, 4'b0000, 0, 0); offer_expect(1);
    // R2: trap mode, ignore pin high has no effect
    setup(1, 1, 1, 1, 4'b0000, 0, 0); offer_expect(2);
    // R3: external mode, ignore sampled high
    setup(0, 1, 1, 1, 4'b0000, 0, 0); offer_expect(1);

    // R4 + R9 + R5: wait, then ignore edge timed
    setup(0, 1, 1, 0, 4'b0000, 0, 0);
    enter_wait("R4 stall while waiting");
    exp_q.push_back(1);
    ign_pin = 1;
    @(negedge clk);
    check(stall_o == 1, "R9 not seen after one edge", stall_o, 1);
    @(negedge clk);
    check(stall_o == 1 && !go_o, "R9 not seen after two edges", go_o, 0);
    @(negedge clk);
    check(go_o == 1, "R9 R5 release on third edge", go_o, 1);
    tgt_valid = 0;
    @(negedge clk);

    // R6: each interrupt-class input releases a wait
    for (int k = 0; k < 4; k++) begin
      setup(0, 1, 1, 0, 4'b0000, 0, 0);
      enter_wait("R4 stall before interrupt");
      exp_q.push_back(3);
      {init_i, nmi_i, smi_i, intr_i} = 4'b0001 << k;
      finish_wait(3);
    end

    // R7: ignore and nmi together
    setup(0, 1, 1, 0, 4'b0000, 0, 0);
    enter_wait("R4 stall before tie");
    exp_q.push_back(3);
    ign_pin = 1; nmi_i = 1;
    finish_wait(3);

    // R8: halt blocks a high ignore pin
    setup(0, 1, 1, 1, 4'b0000, 1, 0);
    enter_wait("R8 halt blocks ignore");
    exp_q.push_back(1);
    pwr_halt = 0;
    finish_wait(1);

    // R8: probe-ready blocks a high ignore pin
    setup(0, 1, 1, 1, 4'b0000, 0, 1);
    enter_wait("R8 probe blocks ignore");
    exp_q.push_back(1);
    probe_rdy = 0;
    finish_wait(1);

    // R10: reset during wait
    setup(0, 1, 1, 0, 4'b0000, 0, 0);
    enter_wait("R4 stall before reset");
    rst_n = 0;
    @(negedge clk);
    tgt_valid = 0;
    check(stall_o == 0, "R10 reset clears wait", stall_o, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!go_o && !trap_o && !irq_exit_o && !stall_o, "R10 idle after reset", stall_o, 0);

    check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule